// File: doc/BRIEF.md
# Pre-Add Multiply-Accumulate Slice

The slice is a pipelined arithmetic element for filters and accumulators. An 18-bit front stage either passes the B operand or forms D plus B or D minus B. That value is multiplied by A in an 18x18 signed multiplier. The 36-bit product, sign-extended, is one of the choices for the X operand of a 48-bit post-adder. The post-adder computes Z + X + carry, or Z - (X + carry), into the P register. P wraps modulo 2^48, and the bit above it is kept as a carry/borrow flag.

An 8-bit operation word is issued together with the data. It travels down the pipeline with its operands, so a new, independent operation can start every cycle. The X operand is one of: zero, the product, the current P, or the 48-bit concatenation of D[11:0], A and B. The Z operand is one of: zero, C, the current P, or the P of a neighbouring slice. Cascade outputs carry the B operand and P onward to that neighbour. The B operand can come either from the local input or from the neighbour's B cascade, chosen by the parameter `B_FROM_CASCADE`.

Two parameters set the optional pipeline registers. `IN_REG` registers the data inputs, and `M_REG` registers the multiplier result. The P register is always present, so the latency is 1 to 3 cycles.

Top module: `premac_slice`

## Requirements
- R1: The synchronous active-high `rst` clears every pipeline register and P. After reset, `p`, `carry_out`, `m_out` and `bcout` are all zero.
- R2: An operation presented on the inputs, together with its opmode and `carry_in`, is reflected in `p`/`carry_out` after IN_REG+M_REG+1 rising edges. One operation can be issued per cycle.
- R3: With opmode[4]=0 the multiplier's second operand is B. With opmode[4]=1 it is D+B, or D-B when opmode[6]=1. The pre-adder result wraps at 18 bits and is read as signed.
- R4: The multiplier forms the signed 18x18 product of A and the pre-adder result. `m_out` presents this 36-bit product IN_REG+M_REG edges after the inputs.
- R5: opmode[1:0] selects X: 0 gives zero, 1 gives the product sign-extended to 48 bits, 2 gives the current P, 3 gives {D[11:0], A, B}.
- R6: opmode[3:2] selects Z: 0 gives zero, 1 gives C, 2 gives the current P, 3 gives `pcin`. The value of `pcin` is taken at the edge that writes P.
- R7: With opmode[7]=0 the new P is Z+X+carry_in; with opmode[7]=1 it is Z-(X+carry_in). Both wrap modulo 2^48. `carry_out` is bit 48 of the 49-bit unsigned result, so in subtraction it is 1 on a borrow.
- R8: `bcout` carries the B operand delayed by IN_REG edges, and `pcout` always equals P. With the default B source, `bcin` has no effect on any output.
- R9: opmode[5] has no effect on any output.
- R10: When X or Z selects P, the value used is the result of the operation issued one cycle earlier. This makes an accumulate, hold, or doubling chain across back-to-back operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a | input | 18 | Multiplier operand, middle field of the concatenation |
| b | input | 18 | Pre-adder operand, low field of the concatenation |
| d | input | 18 | Pre-adder operand; bits 11:0 form the top field of the concatenation |
| c | input | 48 | Z operand choice |
| opmode | input | 8 | Operation word: X select, Z select, pre-add enable, pre-subtract, post-subtract |
| carry_in | input | 1 | Carry added to (or subtracted with) X |
| bcin | input | 18 | B operand from a neighbouring slice |
| pcin | input | 48 | P of a neighbouring slice, a Z operand choice |
| p | output | 48 | Accumulator result |
| carry_out | output | 1 | Bit 48 of the post-adder result (borrow when subtracting) |
| m_out | output | 36 | Multiplier product |
| bcout | output | 18 | B operand to a neighbouring slice |
| pcout | output | 48 | P to a neighbouring slice |

## Verification
The assertions in the post-adder take the operation word, carry and data at its inputs to be known values in every cycle after reset. This lets a selected zero, hold, C pass-through or borrow case be judged from the next value of P. The bench meets that assumption by driving every input with a defined value from time zero, including idle cycles. It also treats `pcin` as the neighbour's output, which is stable while any operation that reads it is in flight. It changes `pcin` only after a run of idle operations has drained the pipeline.

// File: rtl/premac_pkg.sv
package premac_pkg;

    localparam int OPND_W  = 18;
    localparam int PROD_W  = 2 * OPND_W;
    localparam int ACC_W   = 48;
    localparam int DHI_W   = ACC_W - 2 * OPND_W;

    localparam int OPM_PRE_EN   = 4;
    localparam int OPM_PRE_SUB  = 6;
    localparam int OPM_POST_SUB = 7;

    typedef enum logic [1:0] {
        X_ZERO = 2'd0,
        X_PROD = 2'd1,
        X_PFB  = 2'd2,
        X_DAB  = 2'd3
    } xsel_e;

    typedef enum logic [1:0] {
        Z_ZERO = 2'd0,
        Z_C    = 2'd1,
        Z_PFB  = 2'd2,
        Z_PCIN = 2'd3
    } zsel_e;

    typedef struct packed {
        logic [OPND_W-1:0] a;
        logic [OPND_W-1:0] b;
        logic [OPND_W-1:0] d;
        logic [ACC_W-1:0]  c;
        xsel_e             xsel;
        zsel_e             zsel;
        logic              pre_en;
        logic              pre_sub;
        logic              post_sub;
        logic              cin;
    } in_bundle_t;

    typedef struct packed {
        logic [PROD_W-1:0] prod;
        logic [ACC_W-1:0]  dab;
        logic [ACC_W-1:0]  c;
        xsel_e             xsel;
        zsel_e             zsel;
        logic              post_sub;
        logic              cin;
    } mid_bundle_t;

endpackage

// File: rtl/premac_stage.sv
module premac_stage #(
    parameter int W  = 8,
    parameter int EN = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    generate
        if (EN != 0) begin : g_reg
            logic [W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst) q <= '0;
                else     q <= din;
            end
            assign dout = q;
        end else begin : g_wire
            assign dout = din;
        end
    endgenerate

endmodule

// File: rtl/premac_front.sv
module premac_front import premac_pkg::*; (
    input  logic [OPND_W-1:0] a,
    input  logic [OPND_W-1:0] b,
    input  logic [OPND_W-1:0] d,
    input  logic              pre_en,
    input  logic              pre_sub,
    output logic [PROD_W-1:0] prod
);

    logic [OPND_W-1:0]        pre_v;
    logic signed [PROD_W-1:0] mul_s;

    always_comb begin
        if (!pre_en)      pre_v = b;
        else if (pre_sub) pre_v = d - b;
        else              pre_v = d + b;
    end

    assign mul_s = $signed(a) * $signed(pre_v);
    assign prod  = mul_s;

    // R3
    always_comb begin
        if (!pre_en) pre_pass_chk: assert (mul_s == $signed(a) * $signed(b));
    end

endmodule

// File: rtl/premac_post.sv
module premac_post import premac_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  xsel_e             xsel,
    input  zsel_e             zsel,
    input  logic              post_sub,
    input  logic              cin,
    input  logic [PROD_W-1:0] prod,
    input  logic [ACC_W-1:0]  dab,
    input  logic [ACC_W-1:0]  c,
    input  logic [ACC_W-1:0]  pcin,
    output logic [ACC_W-1:0]  p,
    output logic              co
);

    logic [ACC_W-1:0] x_v;
    logic [ACC_W-1:0] z_v;
    logic [ACC_W:0]   sum_v;

    always_comb begin
        unique case (xsel)
            X_ZERO:  x_v = '0;
            X_PROD:  x_v = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
            X_PFB:   x_v = p;
            X_DAB:   x_v = dab;
            default: x_v = '0;
        endcase
    end

    always_comb begin
        unique case (zsel)
            Z_ZERO:  z_v = '0;
            Z_C:     z_v = c;
            Z_PFB:   z_v = p;
            Z_PCIN:  z_v = pcin;
            default: z_v = '0;
        endcase
    end

    always_comb begin
        if (post_sub) sum_v = {1'b0, z_v} - {1'b0, x_v} - (ACC_W+1)'(cin);
        else          sum_v = {1'b0, z_v} + {1'b0, x_v} + (ACC_W+1)'(cin);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            p  <= '0;
            co <= 1'b0;
        end else begin
            {co, p} <= sum_v;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (p == '0 && co == 1'b0));

    // R5
    x_prod_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (xsel == X_PROD && zsel == Z_ZERO && !post_sub && !cin)
        |=> p == {{(ACC_W-PROD_W){$past(prod[PROD_W-1])}}, $past(prod)});

    // R6
    z_c_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (xsel == X_ZERO && zsel == Z_C && !post_sub && !cin) |=> p == $past(c));

    // R10
    p_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (xsel == X_ZERO && zsel == Z_PFB && !post_sub && !cin) |=> $stable(p));

    // R7
    borrow_chk: assert property (@(posedge clk) disable iff (rst)
        (xsel == X_ZERO && zsel == Z_ZERO && post_sub && cin)
        |=> (p == '1 && co == 1'b1));

endmodule

// File: rtl/premac_slice.sv
module premac_slice import premac_pkg::*; #(
    parameter int IN_REG         = 1,
    parameter int M_REG          = 1,
    parameter int B_FROM_CASCADE = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OPND_W-1:0] a,
    input  logic [OPND_W-1:0] b,
    input  logic [OPND_W-1:0] d,
    input  logic [ACC_W-1:0]  c,
    input  logic [7:0]        opmode,
    input  logic              carry_in,
    input  logic [OPND_W-1:0] bcin,
    input  logic [ACC_W-1:0]  pcin,
    output logic [ACC_W-1:0]  p,
    output logic              carry_out,
    output logic [PROD_W-1:0] m_out,
    output logic [OPND_W-1:0] bcout,
    output logic [ACC_W-1:0]  pcout
);

    in_bundle_t        s0, s1;
    mid_bundle_t       m0, m1;
    logic [OPND_W-1:0] b_src;
    logic [PROD_W-1:0] prod;
    logic              unused_op5;

    assign unused_op5 = opmode[5];

    always_comb b_src = (B_FROM_CASCADE != 0) ? bcin : b;

    always_comb begin
        s0.a        = a;
        s0.b        = b_src;
        s0.d        = d;
        s0.c        = c;
        s0.xsel     = xsel_e'(opmode[1:0]);
        s0.zsel     = zsel_e'(opmode[3:2]);
        s0.pre_en   = opmode[OPM_PRE_EN];
        s0.pre_sub  = opmode[OPM_PRE_SUB];
        s0.post_sub = opmode[OPM_POST_SUB];
        s0.cin      = carry_in;
    end

    premac_stage #(.W($bits(in_bundle_t)), .EN(IN_REG)) u_in_stage (
        .clk (clk),
        .rst (rst),
        .din (s0),
        .dout(s1)
    );

    premac_front u_front (
        .a      (s1.a),
        .b      (s1.b),
        .d      (s1.d),
        .pre_en (s1.pre_en),
        .pre_sub(s1.pre_sub),
        .prod   (prod)
    );

    always_comb begin
        m0.prod     = prod;
        m0.dab      = {s1.d[DHI_W-1:0], s1.a, s1.b};
        m0.c        = s1.c;
        m0.xsel     = s1.xsel;
        m0.zsel     = s1.zsel;
        m0.post_sub = s1.post_sub;
        m0.cin      = s1.cin;
    end

    premac_stage #(.W($bits(mid_bundle_t)), .EN(M_REG)) u_mid_stage (
        .clk (clk),
        .rst (rst),
        .din (m0),
        .dout(m1)
    );

    premac_post u_post (
        .clk     (clk),
        .rst     (rst),
        .xsel    (m1.xsel),
        .zsel    (m1.zsel),
        .post_sub(m1.post_sub),
        .cin     (m1.cin),
        .prod    (m1.prod),
        .dab     (m1.dab),
        .c       (m1.c),
        .pcin    (pcin),
        .p       (p),
        .co      (carry_out)
    );

    assign m_out = m1.prod;
    assign bcout = s1.b;
    assign pcout = p;

endmodule

// File: tb/premac_slice_test.sv
module premac_slice_test;

    localparam int IN_T = 1;
    localparam int M_T  = 1;
    localparam int LAT  = IN_T + M_T + 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [17:0] a = '0, b = '0, d = '0, bcin = '0;
    logic [47:0] c = '0, pcin = '0;
    logic [7:0]  opmode = '0;
    logic        carry_in = 1'b0;
    logic [47:0] p, pcout;
    logic        carry_out;
    logic [35:0] m_out;
    logic [17:0] bcout;

    premac_slice #(.IN_REG(IN_T), .M_REG(M_T), .B_FROM_CASCADE(0)) uut (
        .clk(clk), .rst(rst), .a(a), .b(b), .d(d), .c(c), .opmode(opmode),
        .carry_in(carry_in), .bcin(bcin), .pcin(pcin), .p(p),
        .carry_out(carry_out), .m_out(m_out), .bcout(bcout), .pcout(pcout)
    );

    always #5 clk = ~clk;

    typedef struct {
        int unsigned due;
        int          kind;
        logic [48:0] exp;
        string       req;
    } item_t;

    item_t       q[$];
    int unsigned edges = 0;
    int          checks = 0;
    int          fails = 0;
    logic [47:0] model_p = '0;
    bit          done = 1'b0;

    task automatic chk(string req, string what, logic [48:0] act, logic [48:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [35:0] ref_prod(logic [17:0] ia, logic [17:0] ib,
                                             logic [17:0] id, logic [7:0] op);
        logic [17:0]        pre;
        logic signed [35:0] pr;
        if (!op[4])     pre = ib;
        else if (op[6]) pre = id - ib;
        else            pre = id + ib;
        pr = $signed(ia) * $signed(pre);
        return pr;
    endfunction

    function automatic logic [48:0] ref_p(logic [17:0] ia, logic [17:0] ib, logic [17:0] id,
                                          logic [47:0] ic, logic [7:0] op, logic ci,
                                          logic [47:0] pp, logic [47:0] pc);
        logic [35:0] pr;
        logic [47:0] x, z;
        pr = ref_prod(ia, ib, id, op);
        case (op[1:0])
            2'd0:    x = '0;
            2'd1:    x = {{12{pr[35]}}, pr};
            2'd2:    x = pp;
            default: x = {id[11:0], ia, ib};
        endcase
        case (op[3:2])
            2'd0:    z = '0;
            2'd1:    z = ic;
            2'd2:    z = pp;
            default: z = pc;
        endcase
        if (op[7]) return {1'b0, z} - {1'b0, x} - 49'(ci);
        else       return {1'b0, z} + {1'b0, x} + 49'(ci);
    endfunction

    // driver: one call = one issued operation, expected results queued
    task automatic issue(logic [17:0] ia, logic [17:0] ib, logic [17:0] id, logic [47:0] ic,
                         logic [7:0] op, logic ci, string req);
        logic [48:0] r;
        @(negedge clk);
        a = ia; b = ib; d = id; c = ic; opmode = op; carry_in = ci;
        bcin = 18'($urandom);  // R8: must not matter with the local B source
        r = ref_p(ia, ib, id, ic, op, ci, model_p, pcin);
        model_p = r[47:0];
        q.push_back(item_t'{edges + LAT, 0, r, req});
        q.push_back(item_t'{edges + IN_T + M_T, 1, {13'b0, ref_prod(ia, ib, id, op)}, "R4"});
        q.push_back(item_t'{edges + IN_T, 2, {31'b0, ib}, "R8"});
    endtask

    task automatic drain_and_set_pcin(logic [47:0] v);
        for (int i = 0; i < LAT; i++) issue('0, '0, '0, '0, 8'h00, 1'b0, "R2");
        pcin = v;
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            edges++;
            #3;
            for (int i = q.size() - 1; i >= 0; i--) begin
                if (q[i].due == edges) begin
                    case (q[i].kind)
                        0: begin
                            chk(q[i].req, "p/carry", {carry_out, p}, q[i].exp);
                            chk("R8", "pcout", {1'b0, pcout}, {1'b0, q[i].exp[47:0]});
                        end
                        1: chk(q[i].req, "m_out", {13'b0, m_out}, q[i].exp);
                        default: chk(q[i].req, "bcout", {31'b0, bcout}, q[i].exp);
                    endcase
                    q.delete(i);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "p/carry", {carry_out, p}, '0);
        chk("R1", "m_out", {13'b0, m_out}, '0);
        chk("R1", "bcout", {31'b0, bcout}, '0);
        rst = 1'b0;

        // R4 R5 plain signed product
        issue(-18'sd5, 18'sd7, '0, '0, 8'h01, 1'b0, "R5");
        // R3 pre-add and pre-subtract
        issue(18'sd2, -18'sd3, 18'sd100, '0, 8'h11, 1'b0, "R3");
        issue(18'sd2, -18'sd3, 18'sd100, '0, 8'h51, 1'b0, "R3");
        // R3 pre-add 18-bit wrap: 131071 + 1 becomes -131072
        issue(18'sd1, 18'sd1, 18'h1FFFF, '0, 8'h11, 1'b0, "R3");
        // R4 extreme signed product
        issue(18'h20000, 18'h20000, '0, '0, 8'h01, 1'b0, "R4");
        issue(18'h1FFFF, 18'h20000, '0, '0, 8'h01, 1'b0, "R4");
        // R5 concatenation and R6 C pass
        issue(18'h2ABCD, 18'h15432, 18'h3F123, '0, 8'h03, 1'b0, "R5");
        issue('0, '0, '0, 48'h1234_5678_9ABC, 8'h04, 1'b0, "R6");
        // R7 add with carry, subtract, borrow
        issue(18'sd3, 18'sd4, '0, 48'd100, 8'h05, 1'b1, "R7");
        issue(18'sd3, 18'sd4, '0, 48'd100, 8'h85, 1'b1, "R7");
        issue(18'sd30, 18'sd4, '0, 48'd100, 8'h85, 1'b0, "R7");
        issue('0, '0, '0, '0, 8'h80, 1'b1, "R7");
        // R7 modulo wrap with carry out
        issue(18'h3FFFF, 18'h3FFFF, 18'hFFF, 48'hFFFF_FFFF_FFFF, 8'h07, 1'b1, "R7");
        // R10 accumulate, hold, doubling
        issue(18'sd10, 18'sd10, '0, 48'd5, 8'h05, 1'b0, "R10");
        for (int i = 0; i < 5; i++)
            issue(18'(i * 7 - 9), 18'sd13, '0, '0, 8'h09, 1'b0, "R10");
        issue('0, '0, '0, '0, 8'h08, 1'b0, "R10");
        issue('0, '0, '0, '0, 8'h08, 1'b0, "R10");
        for (int i = 0; i < 4; i++) issue('0, '0, '0, '0, 8'h0A, 1'b0, "R10");
        // R9 bit 5 ignored: identical pairs with and without it
        issue(18'sd77, 18'sd11, 18'sd5, 48'd9, 8'h15, 1'b0, "R9");
        issue(18'sd77, 18'sd11, 18'sd5, 48'd9, 8'h35, 1'b0, "R9");
        issue(18'sd77, 18'sd11, 18'sd5, 48'd9, 8'hD5, 1'b1, "R9");
        issue(18'sd77, 18'sd11, 18'sd5, 48'd9, 8'hF5, 1'b1, "R9");
        // R6 cascade P input
        drain_and_set_pcin(48'h8000_0000_0001);
        issue(18'sd6, -18'sd6, '0, '0, 8'h0D, 1'b0, "R6");
        issue(18'sd6, -18'sd6, '0, '0, 8'h8D, 1'b1, "R6");
        issue('0, '0, '0, '0, 8'h0C, 1'b0, "R6");
        // R2 random back-to-back operations
        drain_and_set_pcin({16'($urandom), 32'($urandom)});
        for (int i = 0; i < 300; i++)
            issue(18'($urandom), 18'($urandom), 18'($urandom),
                  {16'($urandom), 32'($urandom)}, 8'($urandom), 1'($urandom), "R2");
        drain_and_set_pcin('0);
        repeat (LAT + 2) @(negedge clk);
        if (q.size() != 0) chk("R2", "queue drained", 49'(q.size()), '0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule